// File: doc/BRIEF.md
# Double-Buffered Sample Capture Controller

This block takes a stream of decoded 16-bit audio samples and stores them into memory buffers through a write port with valid, address, data and ready signals. Software programs a buffer pointer and a buffer size, counted in 16-bit samples, and then issues a start command. The block copies the pointer into its active copy and pulses a started event. It then packs samples into 32-bit words and writes them to consecutive word addresses.

Once the buffer holds the programmed number of samples, the block pulses an end event. In the same cycle it reloads the active pointer from the pointer register, which software may have rewritten during the fill, and pulses started again. Capture therefore continues across a chain of alternating buffers with no lost sample. There are two packing modes. Stereo stores one left/right pair per word. Mono stores two consecutive samples per word. A stop command ends the capture cleanly.

Top module: `acap_top`

## Requirements
- R1: In idle, a start command with a nonzero size latches the pointer register into the active pointer, clears the sample count and overflow flag, and raises `evt_started` for exactly one cycle in the cycle after the command. A start with size zero is ignored.
- R2: Pointer writes only update the pointer register. The active pointer changes only in a cycle where `evt_started` is high. A pointer write in the same cycle as a latch is kept for the next latch, and the latch takes the older value.
- R3: In stereo a word is {right, left}, with left in bits 15:0. In mono a word is {second, first}, with the earlier sample in bits 15:0. The k-th word of a buffer goes to active pointer + 4*k.
- R4: Each stored word adds 2 to the sample count. The word that brings the count to the size raises `evt_end` and `evt_started` together for one cycle. It also clears the count and reloads the active pointer, so the next word goes to offset 0 of the new buffer.
- R5: A size of N samples closes a buffer after N/2 sample strobes in stereo and after N sample strobes in mono.
- R6: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R7: If a word completes while a write is pending and `mem_ready` is low, that word is dropped, the count does not change, and `sts_overflow` is set. The flag stays set until the next accepted start.
- R8: A stop command during capture discards any held mono half-sample and ignores samples from then on. It lets the pending write finish. `evt_end` rises in the cycle after the pending write has gone, the block returns to idle, and no `evt_started` follows.
- R9: A start during capture or drain, a stop in idle, and samples in idle have no effect on the outputs.
- R10: After reset, all outputs and status are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_we | input | 1 | Write strobe for the pointer register |
| ptr_wdata | input | AW | Byte address of the next buffer |
| maxcnt | input | CW | Buffer size in 16-bit samples, even |
| stereo_mode | input | 1 | 1 selects stereo packing, sampled at start |
| start_cmd | input | 1 | Start command pulse |
| stop_cmd | input | 1 | Stop command pulse |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | SW | Left sample, or the mono sample |
| smp_right | input | SW | Right sample, used in stereo |
| mem_valid | output | 1 | Write request pending |
| mem_addr | output | AW | Write byte address |
| mem_data | output | 2*SW | Write data word |
| mem_ready | input | 1 | Memory accepts the pending write |
| evt_started | output | 1 | One-cycle pulse when the active pointer is latched |
| evt_end | output | 1 | One-cycle pulse when a buffer is closed |
| sts_overflow | output | 1 | Sticky flag for dropped words |
| sts_active_ptr | output | AW | Active buffer pointer |
| sts_count | output | CW | Samples stored in the current buffer |

## Verification
The critical collision is a pointer-register write landing in the same cycle as a pointer latch. This can happen on the word that closes a buffer, or together with a start command. The bench provokes both directed cases. It also provokes random pointer writes against random sample and backpressure timing. A cycle-level reference model takes the register value from before the write, and the outputs are compared with it every cycle. A second collision, a completed word meeting a stalled pending write, is forced by holding `mem_ready` low and is judged by the overflow flag and by an unchanged count.

// File: rtl/acap_pkg.sv
package acap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } acap_state_e;
endpackage

// File: rtl/acap_packer.sv
module acap_packer #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          en,
  input  logic          stereo,
  input  logic [SW-1:0] left,
  input  logic [SW-1:0] right,
  output logic          word_v,
  output logic [2*SW-1:0] word
);
  logic          half_v_q;
  logic [SW-1:0] half_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      half_v_q <= 1'b0;
      half_q   <= '0;
    end else if (en && !stereo) begin
      half_v_q <= !half_v_q;
      if (!half_v_q) half_q <= left;
    end
  end

  always_comb begin
    word_v = en && (stereo || half_v_q);
    word   = stereo ? {right, left} : {left, half_q};
  end
endmodule

// File: rtl/acap_ptr_bank.sv
module acap_ptr_bank #(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_we,
  input  logic [AW-1:0] ptr_wdata,
  input  logic [CW-1:0] cfg_max,
  input  logic          latch,
  input  logic          commit,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] active_ptr,
  output logic [CW-1:0] count,
  output logic          boundary
);
  logic [AW-1:0] shadow_q, active_q, off_q;
  logic [CW-1:0] max_q, cnt_q;
  logic [CW:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + (CW+1)'(2);
  assign boundary = commit && (cnt_next >= {1'b0, max_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
      off_q    <= '0;
      max_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (ptr_we) shadow_q <= ptr_wdata;
      if (latch || boundary) begin
        active_q <= shadow_q;
        max_q    <= cfg_max;
        cnt_q    <= '0;
        off_q    <= '0;
      end else if (commit) begin
        cnt_q <= cnt_next[CW-1:0];
        off_q <= off_q + AW'(STEP);
      end
    end
  end

  assign wr_addr    = active_q + off_q;
  assign active_ptr = active_q;
  assign count      = cnt_q;
endmodule

// File: rtl/acap_wr_port.sv
module acap_wr_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          free
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (load) begin
      mem_valid <= 1'b1;
      mem_addr  <= addr;
      mem_data  <= data;
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end

  assign free = !mem_valid || mem_ready;
endmodule

// File: rtl/acap_top.sv
module acap_top #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ptr_we,
  input  logic [AW-1:0]   ptr_wdata,
  input  logic [CW-1:0]   maxcnt,
  input  logic            stereo_mode,
  input  logic            start_cmd,
  input  logic            stop_cmd,
  input  logic            smp_valid,
  input  logic [SW-1:0]   smp_left,
  input  logic [SW-1:0]   smp_right,
  output logic            mem_valid,
  output logic [AW-1:0]   mem_addr,
  output logic [2*SW-1:0] mem_data,
  input  logic            mem_ready,
  output logic            evt_started,
  output logic            evt_end,
  output logic            sts_overflow,
  output logic [AW-1:0]   sts_active_ptr,
  output logic [CW-1:0]   sts_count
);
  import acap_pkg::*;

  localparam int DW   = 2 * SW;
  localparam int STEP = DW / 8;

  acap_state_e state_q;
  logic        stereo_q;
  logic        start_go, stop_go, pk_en, flush;
  logic        word_v, free, commit, boundary;
  logic [DW-1:0] word;
  logic [AW-1:0] wr_addr;

  assign start_go = (state_q == ST_IDLE) && start_cmd && (maxcnt != '0);
  assign stop_go  = (state_q == ST_RUN) && stop_cmd;
  assign pk_en    = (state_q == ST_RUN) && !stop_cmd && smp_valid;
  assign flush    = start_go || stop_go;
  assign commit   = word_v && free;

  acap_packer #(.SW(SW)) u_packer (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .en     (pk_en),
    .stereo (stereo_q),
    .left   (smp_left),
    .right  (smp_right),
    .word_v (word_v),
    .word   (word)
  );

  acap_ptr_bank #(.AW(AW), .CW(CW), .STEP(STEP)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .ptr_we     (ptr_we),
    .ptr_wdata  (ptr_wdata),
    .cfg_max    (maxcnt),
    .latch      (start_go),
    .commit     (commit),
    .wr_addr    (wr_addr),
    .active_ptr (sts_active_ptr),
    .count      (sts_count),
    .boundary   (boundary)
  );

  acap_wr_port #(.AW(AW), .DW(DW)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .load      (commit),
    .addr      (wr_addr),
    .data      (word),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .free      (free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      stereo_q     <= 1'b0;
      evt_started  <= 1'b0;
      evt_end      <= 1'b0;
      sts_overflow <= 1'b0;
    end else begin
      evt_started <= start_go || boundary;
      evt_end     <= boundary || ((state_q == ST_DRAIN) && !mem_valid);
      if (start_go)
        sts_overflow <= 1'b0;
      else if (word_v && !free)
        sts_overflow <= 1'b1;
      case (state_q)
        ST_IDLE: if (start_go) begin
          state_q  <= ST_RUN;
          stereo_q <= stereo_mode;
        end
        ST_RUN:   if (stop_go) state_q <= ST_DRAIN;
        ST_DRAIN: if (!mem_valid) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acap_checker.sv
module acap_checker #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          evt_started,
  input logic          evt_end,
  input logic          sts_overflow,
  input logic [AW-1:0] sts_active_ptr,
  input logic [CW-1:0] sts_count
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R6

  AST_PTR_ONLY_ON_STARTED: assert property (@(posedge clk) disable iff (rst)
    !evt_started |-> $stable(sts_active_ptr)); // R2

  AST_COUNT_ZERO_ON_STARTED: assert property (@(posedge clk) disable iff (rst)
    evt_started |-> sts_count == '0); // R4

  AST_OVF_CLEARS_ON_START: assert property (@(posedge clk) disable iff (rst)
    $fell(sts_overflow) |-> evt_started && !evt_end); // R7

  AST_STOP_END_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    evt_end && !evt_started |-> !mem_valid); // R8
endmodule

bind acap_top acap_checker #(.AW(AW), .CW(CW), .DW(2*SW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mem_valid      (mem_valid),
  .mem_ready      (mem_ready),
  .mem_addr       (mem_addr),
  .mem_data       (mem_data),
  .evt_started    (evt_started),
  .evt_end        (evt_end),
  .sts_overflow   (sts_overflow),
  .sts_active_ptr (sts_active_ptr),
  .sts_count      (sts_count)
);

// File: tb/acap_top_test.sv
`timescale 1ns/1ps
module acap_top_test;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int SW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, ptr_we = 1'b0, stereo_mode = 1'b0;
  logic          start_cmd = 1'b0, stop_cmd = 1'b0, smp_valid = 1'b0, mem_ready = 1'b1;
  logic [AW-1:0] ptr_wdata = '0;
  logic [CW-1:0] maxcnt = '0;
  logic [SW-1:0] smp_left = '0, smp_right = '0;
  logic          mem_valid, evt_started, evt_end, sts_overflow;
  logic [AW-1:0] mem_addr, sts_active_ptr;
  logic [2*SW-1:0] mem_data;
  logic [CW-1:0] sts_count;

  acap_top #(.AW(AW), .CW(CW), .SW(SW)) uut (
    .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .maxcnt(maxcnt),
    .stereo_mode(stereo_mode), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .evt_started(evt_started), .evt_end(evt_end), .sts_overflow(sts_overflow),
    .sts_active_ptr(sts_active_ptr), .sts_count(sts_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state, from the requirements
  int            m_run = 0;
  logic [AW-1:0] m_shadow = '0, m_active = '0, m_off = '0, m_paddr = '0;
  logic [31:0]   m_pdata = '0;
  logic [SW-1:0] m_half = '0;
  int            m_max = 0, m_cnt = 0;
  bit            m_stereo = 0, m_hv = 0, m_pv = 0, m_ovf = 0, m_st = 0, m_en = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit form;
    logic [31:0] w;
    bit n_pv;
    logic [AW-1:0] old_shadow;
    if (rst) begin
      m_run = 0; m_shadow = '0; m_active = '0; m_off = '0; m_max = 0; m_cnt = 0;
      m_stereo = 0; m_hv = 0; m_pv = 0; m_ovf = 0; m_st = 0; m_en = 0;
      return;
    end
    old_shadow = m_shadow;
    if (ptr_we) m_shadow = ptr_wdata;
    n_pv = m_pv && !mem_ready;
    m_st = 0; m_en = 0;
    case (m_run)
      0: if (start_cmd && maxcnt != 0) begin
        m_active = old_shadow; m_max = int'(maxcnt); m_stereo = stereo_mode;
        m_cnt = 0; m_off = '0; m_hv = 0; m_ovf = 0; m_st = 1; m_run = 1;
      end
      1: if (stop_cmd) begin
        m_run = 2; m_hv = 0;
      end else if (smp_valid) begin
        form = 0; w = '0;
        if (m_stereo) begin form = 1; w = {smp_right, smp_left}; end
        else if (!m_hv) begin m_hv = 1; m_half = smp_left; end
        else begin form = 1; w = {smp_left, m_half}; m_hv = 0; end
        if (form) begin
          if (!m_pv || mem_ready) begin
            n_pv = 1; m_paddr = m_active + m_off; m_pdata = w;
            if (m_cnt + 2 >= m_max) begin
              m_active = old_shadow; m_max = int'(maxcnt); m_cnt = 0; m_off = '0;
              m_en = 1; m_st = 1;
            end else begin
              m_cnt = m_cnt + 2; m_off = m_off + 4;
            end
          end else m_ovf = 1;
        end
      end
      default: if (!m_pv) begin m_en = 1; m_run = 0; end
    endcase
    m_pv = n_pv;
  endtask

  task automatic compare();
    chk(mem_valid === m_pv, "R6", "mem_valid", 64'(mem_valid), 64'(m_pv));
    if (m_pv && mem_valid) begin
      chk(mem_addr === m_paddr, "R3", "mem_addr", 64'(mem_addr), 64'(m_paddr));
      chk(mem_data === m_pdata, "R3", "mem_data", 64'(mem_data), 64'(m_pdata));
    end
    chk(evt_started === m_st, "R1", "evt_started", 64'(evt_started), 64'(m_st));
    chk(evt_end === m_en, "R4", "evt_end", 64'(evt_end), 64'(m_en));
    chk(sts_overflow === m_ovf, "R7", "sts_overflow", 64'(sts_overflow), 64'(m_ovf));
    chk(sts_count === CW'(m_cnt), "R4", "sts_count", 64'(sts_count), 64'(m_cnt));
    chk(sts_active_ptr === m_active, "R2", "sts_active_ptr", 64'(sts_active_ptr), 64'(m_active));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    ptr_we = 0; start_cmd = 0; stop_cmd = 0; smp_valid = 0;
  endtask

  task automatic put_sample();
    smp_valid = 1; smp_left = SW'($urandom); smp_right = SW'($urandom);
  endtask

  task automatic wr_ptr(input logic [AW-1:0] p);
    ptr_we = 1; ptr_wdata = p; tick();
  endtask

  // feed one sample per cycle until a buffer closes; return strobes used
  task automatic fill_buffer(input logic [AW-1:0] wr_at_close, input bit do_wr, output int sent);
    sent = 0;
    do begin
      put_sample();
      if (do_wr && (m_cnt + 2 >= m_max) && (m_stereo || m_hv)) begin
        ptr_we = 1; ptr_wdata = wr_at_close;
      end
      tick();
      sent++;
    end while (!evt_end && sent < 64);
  endtask

  task automatic drain_to_idle(output bit saw_start, output bit saw_end);
    saw_start = 0; saw_end = 0;
    for (int i = 0; i < 20 && !saw_end; i++) begin
      tick();
      if (evt_started) saw_start = 1;
      if (evt_end) saw_end = 1;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int sent;
    bit s_st, s_en;
    logic [AW-1:0] keep;
    void'($urandom(32'h1234abcd));
    @(negedge clk);
    rst = 1; repeat (3) tick();
    rst = 0;
    // R10: reset state
    chk(mem_valid === 0 && evt_started === 0 && evt_end === 0, "R10", "reset outputs",
        {61'd0, mem_valid, evt_started, evt_end}, 0);
    chk(sts_overflow === 0 && sts_count === 0 && sts_active_ptr === 0, "R10", "reset status",
        64'(sts_active_ptr), 0);

    // R1/R9: start with size zero is ignored
    wr_ptr(32'h0000_0500);
    maxcnt = 0; start_cmd = 1; tick();
    chk(evt_started === 0, "R1", "zero size start", 64'(evt_started), 0);
    put_sample(); tick(); tick();
    chk(mem_valid === 0, "R9", "sample in idle", 64'(mem_valid), 0);
    stop_cmd = 1; tick();
    chk(evt_end === 0, "R9", "stop in idle", 64'(evt_end), 0);

    // stereo chain with pointer write on the closing word
    mem_ready = 1; stereo_mode = 1; maxcnt = 8;
    wr_ptr(32'h0000_1000);
    start_cmd = 1; tick();
    chk(evt_started === 1 && sts_active_ptr === 32'h1000, "R1", "start latch",
        64'(sts_active_ptr), 64'h1000);
    wr_ptr(32'h0000_3000);
    fill_buffer(32'h0000_4000, 1, sent);
    chk(sent == 4, "R5", "stereo strobes per buffer", 64'(sent), 4);
    chk(sts_active_ptr === 32'h3000 && evt_started === 1, "R2", "latch takes older pointer",
        64'(sts_active_ptr), 64'h3000);
    fill_buffer('0, 0, sent);
    chk(sts_active_ptr === 32'h4000, "R2", "write kept for next latch", 64'(sts_active_ptr), 64'h4000);
    put_sample(); tick();
    stop_cmd = 1; tick();
    drain_to_idle(s_st, s_en);
    chk(s_en && !s_st, "R8", "stop end without started", {62'd0, s_en, s_st}, 2);
    put_sample(); tick(); tick();
    chk(mem_valid === 0, "R9", "sample after stop", 64'(mem_valid), 0);

    // mono, pointer write together with start
    stereo_mode = 0; maxcnt = 6;
    ptr_we = 1; ptr_wdata = 32'h0000_8000; start_cmd = 1; tick();
    chk(sts_active_ptr === 32'h4000, "R2", "start with same-cycle write", 64'(sts_active_ptr), 64'h4000);
    fill_buffer('0, 0, sent);
    chk(sent == 6, "R5", "mono strobes per buffer", 64'(sent), 6);
    tick();
    mem_ready = 0;
    put_sample(); tick();
    put_sample(); tick();
    put_sample(); tick();
    stop_cmd = 1; tick();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(evt_end === 0, "R8", "end waits for write", 64'(evt_end), 0);
    end
    mem_ready = 1; tick();
    chk(evt_end === 0, "R8", "end not with handshake", 64'(evt_end), 0);
    tick();
    chk(evt_end === 1 && evt_started === 0, "R8", "end after write", 64'(evt_end), 1);
    tick();

    // overflow and start during capture
    stereo_mode = 1; maxcnt = 8; mem_ready = 0;
    start_cmd = 1; tick();
    put_sample(); tick();
    put_sample(); tick();
    chk(sts_overflow === 1 && sts_count === 2, "R7", "dropped word", 64'(sts_count), 2);
    mem_ready = 1;
    put_sample(); tick();
    tick();
    keep = sts_active_ptr;
    wr_ptr(32'h0000_9000);
    start_cmd = 1; tick();
    chk(evt_started === 0 && sts_active_ptr === keep, "R9", "start while running",
        64'(sts_active_ptr), 64'(keep));
    chk(sts_overflow === 1, "R7", "flag sticky", 64'(sts_overflow), 1);
    stop_cmd = 1; tick();
    drain_to_idle(s_st, s_en);
    start_cmd = 1; tick();
    chk(sts_overflow === 0, "R7", "flag cleared by start", 64'(sts_overflow), 0);
    stop_cmd = 1; tick();
    drain_to_idle(s_st, s_en);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      mem_ready = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 1) == 1) put_sample();
      if ($urandom_range(0, 9) == 0) begin
        ptr_we = 1; ptr_wdata = {$urandom_range(0, 255), 8'h00} & 32'h0000_FFFC;
      end
      if (m_run == 0 && $urandom_range(0, 7) == 0) begin
        start_cmd = 1; stereo_mode = $urandom_range(0, 1);
        maxcnt = CW'(2 * $urandom_range(0, 8));
      end else if ($urandom_range(0, 79) == 0) begin
        stop_cmd = 1;
      end
      if ($urandom_range(0, 15) == 0) maxcnt = CW'(2 * $urandom_range(1, 8));
      tick();
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule